// File: doc/BRIEF.md
# Trigger-Armed Acquisition Sync Controller

This block is the per-group control unit of a sigma-delta converter group. It runs on the 64x oversample clock and watches an asynchronous bus of eight shared trigger lines. It generates the sample-rate tick from a decimation counter. It offers two one-shot actions, each armed on its own and each tied to its own trigger line. The first action resets the decimation counter, so that every group sharing the trigger line restarts its decimation phase at the same moment. The second action starts buffer capture, and capture always begins on a sample tick at the first word of segment 0.

Host software enables each action and picks its trigger line through one control register, then issues a separate arm command for each action. A hardware edge on the chosen line fires the armed action and disarms it. The converters keep running at all times. Before capture starts, sample ticks produce no buffer writes. After capture starts, every tick writes one block. The write address runs through the words of a segment and then through the segments, and wraps back to segment 0 after the last one. A clear bit in the buffer control word sends the pointer back to segment 0, word 0.

Top module: `acq_sync_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, every output is 0: `dec_rst`, `sample_tick`, `capture_en`, `blk_wr`, `seg_ptr` and `word_ptr`.
- R2: A `cfg_wr` stores control bits. Bit 23 enables the sync reset and bits 22:20 select its trigger line. Bit 19 enables the acquisition start and bits 18:16 select its line. An arm command given while the matching enable bit is 0 is ignored: a later edge on the line does nothing.
- R3: When sync reset is armed, the trigger input on the selected line may be first sampled high at clock edge k. `dec_rst` is then high for exactly the one cycle after edge k+2. The next `sample_tick` comes 64 cycles after that `dec_rst` cycle.
- R4: `sample_tick` is a one-cycle pulse every 64 cycles. After reset is released, the first pulse comes 64 cycles after the reset state.
- R5: Each armed action fires on one edge only and then disarms itself. A second edge with no new arm command does nothing. Edges on lines that are not selected do nothing.
- R6: Once acquisition is armed and its edge fires, `capture_en` rises on the first `sample_tick` strictly after the firing cycle. In that same cycle `blk_wr` pulses with `seg_ptr`=0 and `word_ptr`=0.
- R7: While capturing, every `sample_tick` is followed one cycle later by a `blk_wr` pulse. The address advances `word_ptr` first, then `seg_ptr`, and wraps to segment 0 word 0 after segment SEGS-1 word WORDS-1.
- R8: A `buf_ctl_wr` with bit 9 of `buf_ctl_wdata` set makes the next write go to segment 0, word 0. A write with bit 9 clear leaves the sequence unchanged.
- R9: Before capture starts, no `blk_wr` is produced (those samples are discarded). Once `capture_en` is high it stays high, and a later sync reset does not stop capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversample clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 8 | Asynchronous trigger line bus |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data (bits 23:16 used) |
| buf_ctl_wr | input | 1 | Buffer control write strobe |
| buf_ctl_wdata | input | 32 | Buffer control data (bit 9 = pointer clear) |
| sync_arm | input | 1 | Arm command for the decimation reset |
| acq_arm | input | 1 | Arm command for the capture start |
| dec_rst | output | 1 | One-cycle decimation counter reset pulse |
| sample_tick | output | 1 | Sample-rate tick |
| capture_en | output | 1 | Capture is running |
| blk_wr | output | 1 | Block write strobe into the buffer |
| seg_ptr | output | SEGS bits log2 (2) | Segment of the current write |
| word_ptr | output | WORDS bits log2 (2) | Word within the segment of the current write |

## Verification
The hardest case to reach is the interaction between asynchronous trigger edges and the free-running decimation phase. An acquisition edge has to fire between ticks, and a sync reset has to land while capture is running and move the tick phase under an active write sequence. The bench pulses chosen trigger lines at several offsets, some with the enable bit cleared and some on lines that are not selected. It re-pulses lines that have already fired. It runs capture past the full segment wrap, then issues a buffer clear and a mid-capture sync reset. A behavioural model compares every output on every clock.

// File: rtl/acq_sync_pkg.sv
package acq_sync_pkg;
  localparam int TRIG_LINES   = 8;
  localparam int SEL_W        = $clog2(TRIG_LINES);
  // control register field positions
  localparam int SYNC_EN_BIT  = 23;
  localparam int SYNC_SEL_LSB = 20;
  localparam int ACQ_EN_BIT   = 19;
  localparam int ACQ_SEL_LSB  = 16;
  // buffer control word
  localparam int BUF_CLR_BIT  = 9;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } arm_cfg_t;
endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] trig_async,
  output logic [LINES-1:0] rise
);
  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= trig_async[i];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      assign rise[i] = sync_q & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/oneshot_arm.sv
module oneshot_arm
  import acq_sync_pkg::*;
#(
  parameter int LINES = TRIG_LINES
) (
  input  logic             clk,
  input  logic             rst,
  input  arm_cfg_t         cfg,
  input  logic             arm_cmd,
  input  logic [LINES-1:0] rise,
  output logic             fire
);
  logic armed_q;

  assign fire = armed_q & rise[cfg.sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (arm_cmd && cfg.en) begin
      armed_q <= 1'b1;
    end else if (fire) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/decim_counter.sv
module decim_counter #(
  parameter int DECIM = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic clr_pulse,
  output logic tick
);
  localparam int CNT_W = $clog2(DECIM);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DECIM - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      tick      <= 1'b0;
      clr_pulse <= 1'b0;
    end else if (clr) begin
      cnt_q     <= '0;
      tick      <= 1'b0;
      clr_pulse <= 1'b1;
    end else begin
      clr_pulse <= 1'b0;
      tick      <= (cnt_q == LAST);
      cnt_q     <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/buf_ptr_gen.sv
module buf_ptr_gen #(
  parameter int SEGS  = 4,
  parameter int WORDS = 4,
  localparam int SEG_W  = $clog2(SEGS),
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic              clr,
  output logic              capture,
  output logic              wr,
  output logic [SEG_W-1:0]  seg,
  output logic [WORD_W-1:0] word
);
  localparam logic [SEG_W-1:0]  SEG_LAST  = SEG_W'(SEGS - 1);
  localparam logic [WORD_W-1:0] WORD_LAST = WORD_W'(WORDS - 1);

  logic              pend_q;
  logic [SEG_W-1:0]  nseg_q;
  logic [WORD_W-1:0] nword_q;
  logic [SEG_W-1:0]  base_seg, adv_seg;
  logic [WORD_W-1:0] base_word, adv_word;

  always_comb begin
    base_seg  = capture ? nseg_q  : '0;
    base_word = capture ? nword_q : '0;
    if (base_word == WORD_LAST) begin
      adv_word = '0;
      adv_seg  = (base_seg == SEG_LAST) ? '0 : base_seg + 1'b1;
    end else begin
      adv_word = base_word + 1'b1;
      adv_seg  = base_seg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      capture <= 1'b0;
      wr      <= 1'b0;
      seg     <= '0;
      word    <= '0;
      nseg_q  <= '0;
      nword_q <= '0;
    end else begin
      wr <= 1'b0;
      if (start && !capture) pend_q <= 1'b1;
      if (tick && (pend_q || capture)) begin
        wr      <= 1'b1;
        capture <= 1'b1;
        pend_q  <= 1'b0;
        seg     <= base_seg;
        word    <= base_word;
        nseg_q  <= adv_seg;
        nword_q <= adv_word;
      end
      if (clr) begin
        nseg_q  <= '0;
        nword_q <= '0;
      end
    end
  end
endmodule

// File: rtl/acq_sync_ctrl.sv
module acq_sync_ctrl
  import acq_sync_pkg::*;
#(
  parameter int DECIM = 64,
  parameter int SEGS  = 4,
  parameter int WORDS = 4,
  localparam int SEG_W  = $clog2(SEGS),
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        trig_in,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic              buf_ctl_wr,
  input  logic [31:0]       buf_ctl_wdata,
  input  logic              sync_arm,
  input  logic              acq_arm,
  output logic              dec_rst,
  output logic              sample_tick,
  output logic              capture_en,
  output logic              blk_wr,
  output logic [SEG_W-1:0]  seg_ptr,
  output logic [WORD_W-1:0] word_ptr
);
  arm_cfg_t              sync_cfg_q, acq_cfg_q;
  logic [TRIG_LINES-1:0] rise;
  logic                  sync_fire, acq_fire, buf_clr;
  logic                  unused_bits;

  assign unused_bits = ^{cfg_wdata[31:24], cfg_wdata[15:0],
                         buf_ctl_wdata[31:BUF_CLR_BIT+1], buf_ctl_wdata[BUF_CLR_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_cfg_q <= '0;
      acq_cfg_q  <= '0;
    end else if (cfg_wr) begin
      sync_cfg_q <= '{en: cfg_wdata[SYNC_EN_BIT], sel: cfg_wdata[SYNC_SEL_LSB +: SEL_W]};
      acq_cfg_q  <= '{en: cfg_wdata[ACQ_EN_BIT],  sel: cfg_wdata[ACQ_SEL_LSB +: SEL_W]};
    end
  end

  assign buf_clr = buf_ctl_wr & buf_ctl_wdata[BUF_CLR_BIT];

  trig_edge_detect #(.LINES(TRIG_LINES)) u_edge (
    .clk(clk), .rst(rst), .trig_async(trig_in), .rise(rise)
  );

  oneshot_arm u_sync_arm (
    .clk(clk), .rst(rst), .cfg(sync_cfg_q), .arm_cmd(sync_arm), .rise(rise), .fire(sync_fire)
  );

  oneshot_arm u_acq_arm (
    .clk(clk), .rst(rst), .cfg(acq_cfg_q), .arm_cmd(acq_arm), .rise(rise), .fire(acq_fire)
  );

  decim_counter #(.DECIM(DECIM)) u_decim (
    .clk(clk), .rst(rst), .clr(sync_fire), .clr_pulse(dec_rst), .tick(sample_tick)
  );

  buf_ptr_gen #(.SEGS(SEGS), .WORDS(WORDS)) u_ptr (
    .clk(clk), .rst(rst), .tick(sample_tick), .start(acq_fire), .clr(buf_clr),
    .capture(capture_en), .wr(blk_wr), .seg(seg_ptr), .word(word_ptr)
  );
endmodule

// File: rtl/acq_sync_ctrl_chk.sv
module acq_sync_ctrl_chk #(
  parameter int SEG_W  = 2,
  parameter int WORD_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              dec_rst,
  input logic              sample_tick,
  input logic              capture_en,
  input logic              blk_wr,
  input logic [SEG_W-1:0]  seg_ptr,
  input logic [WORD_W-1:0] word_ptr
);
  // R3
  dec_rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    dec_rst |=> !dec_rst);
  // R4
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !sample_tick);
  // R6
  start_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(capture_en) |-> (blk_wr && seg_ptr == '0 && word_ptr == '0));
  // R7
  wr_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    blk_wr |-> $past(sample_tick));
  // R9
  wr_needs_capture_chk: assert property (@(posedge clk) disable iff (rst)
    blk_wr |-> capture_en);
  // R9
  capture_holds_chk: assert property (@(posedge clk) disable iff (rst)
    capture_en |=> capture_en);
endmodule

bind acq_sync_ctrl acq_sync_ctrl_chk #(.SEG_W(SEG_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .dec_rst(dec_rst), .sample_tick(sample_tick),
  .capture_en(capture_en), .blk_wr(blk_wr), .seg_ptr(seg_ptr), .word_ptr(word_ptr)
);

// File: tb/acq_sync_ctrl_bench.sv
module acq_sync_ctrl_bench;
  localparam int DECIM = 64;
  localparam int SEGS  = 4;
  localparam int WORDS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  trig_in = '0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        buf_ctl_wr = 1'b0;
  logic [31:0] buf_ctl_wdata = '0;
  logic        sync_arm = 1'b0;
  logic        acq_arm = 1'b0;
  logic        dec_rst, sample_tick, capture_en, blk_wr;
  logic [1:0]  seg_ptr, word_ptr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acq_sync_ctrl #(.DECIM(DECIM), .SEGS(SEGS), .WORDS(WORDS)) u_acq_sync_ctrl (
    .clk(clk), .rst(rst), .trig_in(trig_in), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .buf_ctl_wr(buf_ctl_wr), .buf_ctl_wdata(buf_ctl_wdata), .sync_arm(sync_arm),
    .acq_arm(acq_arm), .dec_rst(dec_rst), .sample_tick(sample_tick),
    .capture_en(capture_en), .blk_wr(blk_wr), .seg_ptr(seg_ptr), .word_ptr(word_ptr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_cfg, m_cnt, m_nidx, m_seg, m_word;
  bit  m_sarm, m_aarm, m_pend, m_cap, m_tick, m_drst, m_wr;
  bit [7:0] h1, h2, h3;

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 0; m_cnt = 0; m_nidx = 0; m_seg = 0; m_word = 0;
      m_sarm = 0; m_aarm = 0; m_pend = 0; m_cap = 0; m_tick = 0; m_drst = 0; m_wr = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit fs, fa, old_tick, old_cap, old_pend;
      int ssel, asel, widx;
      ssel = (m_cfg >> 20) & 7;
      asel = (m_cfg >> 16) & 7;
      fs = m_sarm && h2[ssel] && !h3[ssel];
      fa = m_aarm && h2[asel] && !h3[asel];
      old_tick = m_tick; old_cap = m_cap; old_pend = m_pend;
      m_wr = 0;
      if (fa && !old_cap) m_pend = 1;
      if (old_tick && (old_pend || old_cap)) begin
        widx = old_cap ? m_nidx : 0;
        m_wr = 1; m_cap = 1; m_pend = 0;
        m_seg = widx / WORDS; m_word = widx % WORDS;
        m_nidx = (widx + 1) % (SEGS * WORDS);
      end
      if (buf_ctl_wr && buf_ctl_wdata[9]) m_nidx = 0;
      m_drst = fs;
      if (fs) begin m_cnt = 0; m_tick = 0; end
      else begin m_tick = (m_cnt == DECIM - 1); m_cnt = (m_cnt + 1) % DECIM; end
      if (sync_arm && m_cfg[23]) m_sarm = 1; else if (fs) m_sarm = 0;
      if (acq_arm && m_cfg[19]) m_aarm = 1; else if (fa) m_aarm = 0;
      if (cfg_wr) m_cfg = int'(cfg_wdata);
      h3 = h2; h2 = h1; h1 = trig_in;
    end
  end

  // event monitors and per-clock comparison
  int n_drst = 0, n_wr = 0, cyc = 0, drst_cyc = -1, tick_gap = -1;
  int wr_seg[$], wr_word[$];

  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      check(dec_rst == m_drst, "R3 dec_rst", dec_rst, m_drst);
      check(sample_tick == m_tick, "R4 sample_tick", sample_tick, m_tick);
      check(capture_en == m_cap, "R6 capture_en", capture_en, m_cap);
      check(blk_wr == m_wr, "R9 blk_wr", blk_wr, m_wr);
      check(seg_ptr == m_seg[1:0], "R7 seg_ptr", seg_ptr, m_seg);
      check(word_ptr == m_word[1:0], "R7 word_ptr", word_ptr, m_word);
      if (dec_rst) begin n_drst++; drst_cyc = cyc; tick_gap = -1; end
      if (sample_tick && drst_cyc >= 0 && tick_gap < 0) tick_gap = cyc - drst_cyc;
      if (blk_wr) begin n_wr++; wr_seg.push_back(seg_ptr); wr_word.push_back(word_ptr); end
    end
  end

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic pulse_arm(input bit which_acq);
    @(negedge clk); if (which_acq) acq_arm = 1; else sync_arm = 1;
    @(negedge clk); acq_arm = 0; sync_arm = 0;
  endtask

  task automatic pulse_trig(input int line);
    @(negedge clk); trig_in[line] = 1;
    repeat (3) @(negedge clk);
    trig_in[line] = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic buf_write(input logic [31:0] v);
    @(negedge clk); buf_ctl_wr = 1; buf_ctl_wdata = v;
    @(negedge clk); buf_ctl_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    // R1 reset state
    repeat (3) @(negedge clk);
    check({dec_rst, sample_tick, capture_en, blk_wr, seg_ptr, word_ptr} == 0, "R1 reset", 1, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check({dec_rst, sample_tick, capture_en, blk_wr, seg_ptr, word_ptr} == 0, "R1 after release", 1, 0);

    // R4 / R9 free-running ticks, nothing written
    repeat (140) @(negedge clk);
    check(n_wr == 0, "R9 no writes before capture", n_wr, 0);

    // R2 arm ignored with enable clear (line 3 selected)
    write_cfg(32'h0030_0000);
    pulse_arm(0);
    pulse_trig(3);
    check(n_drst == 0, "R2 disabled arm ignored", n_drst, 0);

    // R5 wrong line, then R3 selected line 5, then R5 second edge
    write_cfg(32'h00D0_0000);
    pulse_arm(0);
    pulse_trig(2);
    check(n_drst == 0, "R5 unselected line", n_drst, 0);
    pulse_trig(5);
    check(n_drst == 1, "R3 sync reset fired", n_drst, 1);
    pulse_trig(5);
    check(n_drst == 1, "R5 fires once", n_drst, 1);
    repeat (70) @(negedge clk);
    check(tick_gap == 64, "R3 tick after dec_rst", tick_gap, 64);

    // R6 acquisition on line 1, R2 enable bit 19
    write_cfg(32'h0009_0000);
    pulse_arm(1);
    repeat (10) @(negedge clk);
    pulse_trig(1);
    repeat (DECIM + 4) @(negedge clk);
    check(capture_en == 1, "R6 capture started", capture_en, 1);
    check(n_wr == 1, "R6 one write after first tick", n_wr, 1);
    if (n_wr >= 1) check(wr_seg[0] == 0 && wr_word[0] == 0, "R6 first address", wr_seg[0] * 4 + wr_word[0], 0);

    // R7 run through full wrap
    repeat (18 * DECIM) @(negedge clk);
    check(n_wr >= 18, "R7 write count", n_wr, 18);
    if (n_wr >= 18) begin
      check(wr_seg[4] == 1 && wr_word[4] == 0, "R7 segment step", wr_seg[4] * 4 + wr_word[4], 4);
      check(wr_seg[15] == 3 && wr_word[15] == 3, "R7 last slot", wr_seg[15] * 4 + wr_word[15], 15);
      check(wr_seg[16] == 0 && wr_word[16] == 0, "R7 wrap", wr_seg[16] * 4 + wr_word[16], 0);
    end

    // R8 write without clear bit, then with clear bit
    buf_write(32'h0000_0100);
    base = n_wr;
    repeat (DECIM + 2) @(negedge clk);
    check(n_wr > base && !(wr_seg[base] == 0 && wr_word[base] == 0 && wr_seg[base-1] != 3),
          "R8 no-clear write ignored", n_wr - base, 1);
    buf_write(32'h0000_0200);
    base = n_wr;
    repeat (DECIM + 2) @(negedge clk);
    check(n_wr > base && wr_seg[base] == 0 && wr_word[base] == 0, "R8 clear to zero",
          (n_wr > base) ? wr_seg[base] * 4 + wr_word[base] : -1, 0);

    // R9 sync reset during capture keeps capture running
    write_cfg(32'h00D9_0000);
    pulse_arm(0);
    repeat (17) @(negedge clk);
    pulse_trig(5);
    check(n_drst == 2, "R9 sync reset while capturing", n_drst, 2);
    base = n_wr;
    repeat (3 * DECIM) @(negedge clk);
    check(capture_en == 1 && n_wr - base >= 2, "R9 capture continues", n_wr - base, 3);

    finish_run();
  end
endmodule